// File: doc/BRIEF.md
# Single-Block Hash Key Diversifier

This block turns one shared secret into a secret unique to a single tag. It holds a small bank of 64-bit secret slots. Software can write these slots but can never read them back. A hash request names a slot and supplies a 64-bit tag identifier and a 64-bit diversifier. The block joins the slot secret, the identifier and the diversifier in that order. It pads the 24-byte message into one 512-bit SHA-1 block and runs the 80 rounds of a single SHA-1 compression, one round per clock. The result is a 160-bit digest.

A request that names an unpopulated slot is refused with a one-cycle error pulse and starts no computation. A lock input freezes the slot contents until the next reset. The only data that leaves the block is the digest. Slot contents reach the outputs only through that hash.

Top module: `hkd_diversifier`

## Requirements
- R1: `digest` equals SHA-1 over one block made of the slot secret (first 8 bytes), then `tag_id`, then `kid`, each big-endian. The block then holds byte 0x80, zero fill, and the 64-bit length 192 in its last 8 bytes.
- R2: A `start` seen while idle, with `slot_sel` below 12, raises `busy` on the next cycle. `busy` then stays high for exactly 80 cycles.
- R3: `done` is high for exactly one cycle, the cycle right after `busy` falls. `digest` is valid in that cycle and holds its value until the next `done`.
- R4: A `start` seen while idle with `slot_sel` of 12 or more raises `err` for exactly one cycle, in the cycle after `start`. `busy` and `done` stay low and `digest` is unchanged.
- R5: A `start` seen while `busy` is high is ignored. The running result is unaffected and no second computation follows.
- R6: While `locked` is low, a cycle with `slot_we` high and `slot_waddr` below 12 replaces that slot's secret. Later hashes use the new secret.
- R7: One cycle with `lock_set` high makes `locked` high from the next cycle until reset. While `locked` is high, slot writes have no effect.
- R8: Reset clears `busy`, `done`, `err`, `locked` and `digest` to zero and clears every slot to zero.
- R9: `slot_sel`, `tag_id` and `kid` are captured on the `start` cycle. Changing them while `busy` is high does not change the result.
- R10: A slot write changes no output port. Secrets are observable only through the digest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_we | input | 1 | Slot write strobe |
| slot_waddr | input | 4 | Slot to write |
| slot_wdata | input | 64 | Secret value to store |
| lock_set | input | 1 | Freeze all slots until reset |
| start | input | 1 | Launch a hash |
| slot_sel | input | 4 | Slot holding the secret to hash |
| tag_id | input | 64 | Tag identifier |
| kid | input | 64 | System diversifier |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle digest-ready pulse |
| err | output | 1 | One-cycle pulse for a refused request |
| locked | output | 1 | Slots are frozen |
| digest | output | 160 | Derived secret |

## Verification
All results follow a fixed cycle schedule from the `start` edge:
- `busy` is high one cycle later.
- `done` and the new `digest` appear 81 cycles later.
- `err` appears one cycle later.
- `locked` rises one cycle after `lock_set`.

The bench drives inputs on falling edges and samples outputs on falling edges. It counts `busy` cycles instead of assuming them. It then compares `done`, `digest` and `err` exactly in the cycle the schedule names, and again in the cycle after, which confirms the one-cycle pulses and the held digest.

// File: rtl/hkd_pkg.sv
package hkd_pkg;
  localparam int ROUNDS    = 80;
  localparam int BLOCK_W   = 512;
  localparam int DIGEST_W  = 160;
  localparam int LENFLD_W  = 64;

  localparam logic [31:0] IV0 = 32'h67452301;
  localparam logic [31:0] IV1 = 32'hEFCDAB89;
  localparam logic [31:0] IV2 = 32'h98BADCFE;
  localparam logic [31:0] IV3 = 32'h10325476;
  localparam logic [31:0] IV4 = 32'hC3D2E1F0;

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  // Round-dependent boolean mix of the b, c, d words.
  function automatic logic [31:0] mix(input logic [6:0] r, input logic [31:0] b,
                                      input logic [31:0] c, input logic [31:0] d);
    if (r < 7'd20)      return (b & c) | (~b & d);
    else if (r < 7'd40) return b ^ c ^ d;
    else if (r < 7'd60) return (b & c) | (b & d) | (c & d);
    else                return b ^ c ^ d;
  endfunction

  function automatic logic [31:0] rconst(input logic [6:0] r);
    if (r < 7'd20)      return 32'h5A827999;
    else if (r < 7'd40) return 32'h6ED9EBA1;
    else if (r < 7'd60) return 32'h8F1BBCDC;
    else                return 32'hCA62C1D6;
  endfunction
endpackage

// File: rtl/hkd_secret_bank.sv
module hkd_secret_bank #(
  parameter int SLOT_CNT = 12,
  parameter int IDX_W    = 4,
  parameter int SECRET_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [IDX_W-1:0]    waddr,
  input  logic [SECRET_W-1:0] wdata,
  input  logic                lock_set,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [SECRET_W-1:0] rd_data,
  output logic                locked
);
  logic [SLOT_CNT-1:0][SECRET_W-1:0] mem_q;
  logic                              lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (lock_set) begin
      lock_q <= 1'b1;
    end
  end

  for (genvar s = 0; s < SLOT_CNT; s++) begin : g_slot
    logic hit;
    assign hit = we && !lock_q && (int'(waddr) == s);
    always_ff @(posedge clk) begin
      if (!rst_n)   mem_q[s] <= '0;
      else if (hit) mem_q[s] <= wdata;
    end
  end

  // Internal read port only: feeds the block builder, never a block output.
  always_comb begin
    rd_data = '0;
    for (int s = 0; s < SLOT_CNT; s++)
      if (int'(rd_idx) == s) rd_data = mem_q[s];
  end

  assign locked = lock_q;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R7
  AST_FROZEN_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(mem_q)); // R7
endmodule

// File: rtl/hkd_block_pad.sv
module hkd_block_pad
  import hkd_pkg::*;
#(
  parameter int SECRET_W = 64,
  parameter int ID_W     = 64,
  parameter int KID_W    = 64
) (
  input  logic [SECRET_W-1:0] secret,
  input  logic [ID_W-1:0]     id,
  input  logic [KID_W-1:0]    kid,
  output logic [BLOCK_W-1:0]  blk,
  output logic                too_long
);
  localparam int MSG_W  = SECRET_W + ID_W + KID_W;
  localparam int ROOM_W = BLOCK_W - LENFLD_W - 8;

  if (MSG_W <= ROOM_W) begin : g_fit
    localparam int FILL_W = BLOCK_W - MSG_W - 1 - LENFLD_W;
    assign blk      = {secret, id, kid, 1'b1, {FILL_W{1'b0}}, LENFLD_W'(MSG_W)};
    assign too_long = 1'b0;
  end else begin : g_overflow
    logic unused_in;
    assign unused_in = ^{secret, id, kid};
    assign blk       = '0;
    assign too_long  = 1'b1;
  end
endmodule

// File: rtl/hkd_sha1_engine.sv
module hkd_sha1_engine
  import hkd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [BLOCK_W-1:0]  blk,
  output logic                busy,
  output logic                done,
  output logic [DIGEST_W-1:0] digest
);
  logic [15:0][31:0] win_q;
  logic [31:0] a_q, b_q, c_q, d_q, e_q;
  logic [6:0]  rnd_q;
  logic        busy_q, done_q;
  logic [DIGEST_W-1:0] dig_q;

  logic [31:0] sched_next, t_word;
  logic        round_last;

  assign sched_next = rotl(win_q[13] ^ win_q[8] ^ win_q[2] ^ win_q[0], 1);
  assign t_word     = rotl(a_q, 5) + mix(rnd_q, b_q, c_q, d_q) + e_q + rconst(rnd_q) + win_q[0];
  assign round_last = busy_q && (rnd_q == 7'(ROUNDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dig_q  <= '0;
      rnd_q  <= '0;
      win_q  <= '0;
      {a_q, b_q, c_q, d_q, e_q} <= '0;
    end else begin
      done_q <= 1'b0;
      if (load && !busy_q) begin
        for (int j = 0; j < 16; j++) win_q[j] <= blk[BLOCK_W-1-32*j -: 32];
        {a_q, b_q, c_q, d_q, e_q} <= {IV0, IV1, IV2, IV3, IV4};
        rnd_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        for (int j = 0; j < 15; j++) win_q[j] <= win_q[j+1];
        win_q[15] <= sched_next;
        a_q <= t_word;
        b_q <= a_q;
        c_q <= rotl(b_q, 30);
        d_q <= c_q;
        e_q <= d_q;
        rnd_q <= rnd_q + 7'd1;
        if (round_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          dig_q  <= {IV0 + t_word, IV1 + a_q, IV2 + rotl(b_q, 30), IV3 + c_q, IV4 + d_q};
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign digest = dig_q;

  AST_ROUND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rnd_q < 7'(ROUNDS))); // R2
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $fell(busy_q)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R3
  AST_DIGEST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(dig_q)); // R3
endmodule

// File: rtl/hkd_diversifier.sv
module hkd_diversifier
  import hkd_pkg::*;
#(
  parameter int SLOT_CNT = 12,
  parameter int IDX_W    = 4,
  parameter int SECRET_W = 64,
  parameter int ID_W     = 64,
  parameter int KID_W    = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slot_we,
  input  logic [IDX_W-1:0]    slot_waddr,
  input  logic [SECRET_W-1:0] slot_wdata,
  input  logic                lock_set,
  input  logic                start,
  input  logic [IDX_W-1:0]    slot_sel,
  input  logic [ID_W-1:0]     tag_id,
  input  logic [KID_W-1:0]    kid,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic                locked,
  output logic [DIGEST_W-1:0] digest
);
  logic [SECRET_W-1:0] sel_secret;
  logic [BLOCK_W-1:0]  block;
  logic                too_long, sel_ok, accept, refuse, err_q;

  hkd_secret_bank #(.SLOT_CNT(SLOT_CNT), .IDX_W(IDX_W), .SECRET_W(SECRET_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(slot_we), .waddr(slot_waddr), .wdata(slot_wdata),
    .lock_set(lock_set), .rd_idx(slot_sel), .rd_data(sel_secret), .locked(locked));

  hkd_block_pad #(.SECRET_W(SECRET_W), .ID_W(ID_W), .KID_W(KID_W)) u_pad (
    .secret(sel_secret), .id(tag_id), .kid(kid), .blk(block), .too_long(too_long));

  assign sel_ok = int'(slot_sel) < SLOT_CNT;
  assign accept = start && !busy && sel_ok && !too_long;
  assign refuse = start && !busy && !(sel_ok && !too_long);

  hkd_sha1_engine u_eng (
    .clk(clk), .rst_n(rst_n), .load(accept), .blk(block),
    .busy(busy), .done(done), .digest(digest));

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= refuse;
  end
  assign err = err_q;

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !done)); // R4
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err || $past(start)); // R4
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R2
endmodule

// File: tb/hkd_diversifier_test.sv
`timescale 1ns/1ps
module hkd_diversifier_test;
  logic clk = 0, rst_n = 0;
  logic slot_we = 0, lock_set = 0, start = 0;
  logic [3:0] slot_waddr = 0, slot_sel = 0;
  logic [63:0] slot_wdata = 0, tag_id = 0, kid = 0;
  logic busy, done, err, locked;
  logic [159:0] digest;

  int checks = 0, errors = 0;
  logic [63:0] model [16];
  bit model_lock = 0;

  always #4 clk = ~clk;

  hkd_diversifier uut (
    .clk(clk), .rst_n(rst_n), .slot_we(slot_we), .slot_waddr(slot_waddr),
    .slot_wdata(slot_wdata), .lock_set(lock_set), .start(start), .slot_sel(slot_sel),
    .tag_id(tag_id), .kid(kid), .busy(busy), .done(done), .err(err),
    .locked(locked), .digest(digest));

  function automatic logic [159:0] ref_hash(input logic [63:0] s, input logic [63:0] i,
                                            input logic [63:0] k);
    logic [511:0] m;
    logic [31:0] w [80];
    logic [31:0] x, a, b, c, d, e, f, kk, tmp;
    m = {s, i, k, 8'h80, 248'h0, 64'd192};
    for (int t = 0; t < 16; t++) w[t] = m[511-32*t -: 32];
    for (int t = 16; t < 80; t++) begin
      x = w[t-3] ^ w[t-8] ^ w[t-14] ^ w[t-16];
      w[t] = {x[30:0], x[31]};
    end
    a = 32'h67452301; b = 32'hEFCDAB89; c = 32'h98BADCFE; d = 32'h10325476; e = 32'hC3D2E1F0;
    for (int t = 0; t < 80; t++) begin
      case (t / 20)
        0: begin f = (b & c) | (~b & d);          kk = 32'h5A827999; end
        1: begin f = b ^ c ^ d;                   kk = 32'h6ED9EBA1; end
        2: begin f = (b & c) | (b & d) | (c & d); kk = 32'h8F1BBCDC; end
        default: begin f = b ^ c ^ d;             kk = 32'hCA62C1D6; end
      endcase
      tmp = {a[26:0], a[31:27]} + f + e + kk + w[t];
      e = d; d = c; c = {b[1:0], b[31:2]}; b = a; a = tmp;
    end
    return {a + 32'h67452301, b + 32'hEFCDAB89, c + 32'h98BADCFE,
            d + 32'h10325476, e + 32'hC3D2E1F0};
  endfunction

  task automatic check(input bit ok, input string req, input logic [159:0] act,
                       input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int s = 0; s < 16; s++) model[s] = '0;
    model_lock = 0;
    @(negedge clk);
  endtask

  task automatic write_slot(input logic [3:0] a, input logic [63:0] v);
    logic [159:0] dig_before;
    dig_before = digest;
    @(negedge clk); slot_we = 1; slot_waddr = a; slot_wdata = v;
    @(negedge clk); slot_we = 0;
    if (!model_lock && a < 12) model[a] = v;
    // R10: a write touches no output
    check(digest == dig_before && !busy && !done && !err, "R10", digest, dig_before);
  endtask

  task automatic do_hash(input logic [3:0] sl, input logic [63:0] id, input logic [63:0] kd,
                         input string tag);
    logic [159:0] exp;
    int cnt;
    exp = ref_hash(model[sl], id, kd);
    @(negedge clk); slot_sel = sl; tag_id = id; kid = kd; start = 1;
    @(negedge clk); start = 0;
    cnt = 0;
    while (busy && cnt < 200) begin cnt++; @(negedge clk); end
    check(cnt == 80, "R2 busy length", 160'(cnt), 160'd80);
    check(done == 1'b1, "R3 done", 160'(done), 160'd1);
    check(digest == exp, tag, digest, exp);
    @(negedge clk);
    check(done == 1'b0 && digest == exp, "R3 pulse/held", digest, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [159:0] exp, prev;
    int cnt;
    void'($urandom(32'd1234));
    do_reset();
    // R8: reset state
    check(!busy && !done && !err && !locked, "R8 flags", {busy, done, err, locked}, 160'd0);
    check(digest == '0, "R8 digest", digest, 160'd0);
    do_hash(4'd3, 64'h0, 64'h0, "R8 zero slot R1");

    // R6: populate slots
    for (int s = 0; s < 12; s++) write_slot(4'(s), {$urandom, $urandom});

    // R1 directed corners
    do_hash(4'd0, 64'h0, 64'h0, "R1 slot0 zeros");
    do_hash(4'd11, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R1 last slot ones");
    do_hash(4'd5, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, "R1 order");

    // R1 random
    for (int n = 0; n < 16; n++)
      do_hash(4'($urandom_range(0, 11)), {$urandom, $urandom}, {$urandom, $urandom}, "R1 random");

    // R4: unpopulated slots
    for (int n = 0; n < 2; n++) begin
      prev = digest;
      @(negedge clk); slot_sel = (n == 0) ? 4'd12 : 4'd15; start = 1;
      @(negedge clk); start = 0;
      check(err == 1'b1 && !busy, "R4 err pulse", {err, busy}, 160'b10);
      @(negedge clk);
      check(!err && !done && !busy && digest == prev, "R4 quiet", digest, prev);
    end

    // R5 / R9: restart attempt and input change while busy
    exp = ref_hash(model[7], 64'hAAAA_5555_AAAA_5555, 64'h1111_2222_3333_4444);
    @(negedge clk); slot_sel = 4'd7; tag_id = 64'hAAAA_5555_AAAA_5555;
    kid = 64'h1111_2222_3333_4444; start = 1;
    @(negedge clk); start = 0;
    cnt = 1;
    repeat (10) begin @(negedge clk); cnt++; end
    slot_sel = 4'd2; tag_id = 64'h0; kid = {$urandom, $urandom}; start = 1;
    @(negedge clk); start = 0; cnt++;
    while (busy && cnt < 200) begin @(negedge clk); if (busy) cnt++; end
    check(cnt == 80, "R5 busy length", 160'(cnt), 160'd80);
    check(done && digest == exp, "R9 captured inputs", digest, exp);
    @(negedge clk);
    check(!busy && !done, "R5 no restart", {busy, done}, 160'd0);

    // R6: overwrite before lock
    write_slot(4'd2, 64'hDEAD_BEEF_0BAD_F00D);
    do_hash(4'd2, 64'h42, 64'h99, "R6 new secret");

    // R7: lock
    @(negedge clk); lock_set = 1;
    @(negedge clk); lock_set = 0;
    check(locked == 1'b1, "R7 locked", 160'(locked), 160'd1);
    repeat (3) @(negedge clk);
    check(locked == 1'b1, "R7 sticky", 160'(locked), 160'd1);
    model_lock = 1;
    write_slot(4'd2, 64'h1234_5678_1234_5678);
    do_hash(4'd2, 64'h42, 64'h99, "R7 write ignored");

    // R8: reset clears lock and slots
    do_reset();
    check(!locked && digest == '0, "R8 second reset", {locked, digest}, 160'd0);
    do_hash(4'd2, 64'h42, 64'h99, "R8 slot cleared");
    write_slot(4'd2, 64'h5555_AAAA_5555_AAAA);
    do_hash(4'd2, 64'h42, 64'h99, "R6 after unlock");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule